// File: doc/BRIEF.md
# Per-User Virtual-to-Physical Page Translator

This block turns a virtual data address into a physical one for a machine in which each of 256 user identities owns a private page table. Pages hold 4096 words. The low 12 address bits are the offset within a page and pass through unchanged. The bits just above the offset pick a virtual page, and the user identity selects whose table is consulted. No entry carries a valid flag, so every page of every user maps to some physical page. Keeping each entry pointed at memory that user may touch is the job of system software.

Each table entry is 18 bits wide. Sixteen bits give the physical page base, which is physical address bits 27..12. The other two bits are the chip-select bit and the write-protect bit. These two bits keep their positions at the top of the physical address, bits 34 and 35. The block accepts four operations. Idle does nothing. Translate serves unprivileged loads and stores. Table read returns the physical base of a page. Table write updates an entry. A table read leaves physical bits 33..28 without meaning: they carry whatever a free-running register held, and callers must mask them off.

Top module: `page_xlate`

## Requirements
- R1: Translate (opSel = 1): one clock edge after the request, physAddr[11:0] equals virtAddr[11:0] from the request.
- R2: Translate: physAddr[27:12] equals entry bits 15..0, physAddr[34] equals entry bit 16 and physAddr[35] equals entry bit 17. The entry is the one at index {userId, virtAddr[12 +: PAGE_BITS]}. physAddr[33:28] reads zero.
- R3: Table read (opSel = 2): one clock edge after the request, physAddr[11:0] is zero. Bits 35, 34 and 27..12 hold the addressed entry laid out as in R2. Only the bits under the mask 36'hC_0FFF_FFFF are defined.
- R4: Table write (opSel = 3) stores wrData[27:12] into entry bits 15..0, wrData[34] into entry bit 16 and wrData[35] into entry bit 17. wrData[33:28] and wrData[11:0] are ignored, and so are virtAddr[11:0].
- R5: Each user identity has its own table. A write for one user leaves the same virtual page of every other user unchanged.
- R6: physAddr keeps its value, all 36 bits, across idle (opSel = 0) and table-write cycles.
- R7: While rstN is low, physAddr is zero.
- R8: A read or translate issued on the cycle right after a write to the same entry returns the newly written value.
- R9: virtAddr bits above bit 11+PAGE_BITS are ignored by translate and by table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| userId | input | 8 | Identity selecting the page table |
| virtAddr | input | 36 | Virtual address: page number and offset |
| opSel | input | 2 | Operation: 0 idle, 1 translate, 2 table read, 3 table write |
| wrData | input | 36 | Physical base with the protect and select bits, used on table write |
| physAddr | output | 36 | Translated address or table readback |

## Verification
Translate and table-read results are due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and compares physAddr shortly after the next rising edge, before any later request can reach the output. A table write changes nothing visible in that same cycle. Its effect is checked by the read or translate that follows on the very next cycle, which also covers the write-then-read case. Hold behaviour is checked by comparing the whole output after an idle or write cycle against the value it had just before.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_XLATE = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tblWr;     // store entry
    logic lookup;    // fetch entry and update output state
    logic showBase;  // output presents table readback, not translation
  } ptStrobe_t;
endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
(
  input  logic [1:0] opSel,
  output ptStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    unique case (op_e'(opSel))
      OP_XLATE: strobe.lookup = 1'b1;
      OP_READ: begin
        strobe.lookup   = 1'b1;
        strobe.showBase = 1'b1;
      end
      OP_WRITE: strobe.tblWr = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
#(
  parameter int USER_BITS = 8,
  parameter int PAGE_BITS = 3,
  parameter int OFF_BITS  = 12,
  parameter int BASE_BITS = 16,
  parameter int ADDR_W    = 36
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ptStrobe_t            strobe,
  input  logic [USER_BITS-1:0] userId,
  input  logic [ADDR_W-1:0]    virtAddr,
  input  logic [ADDR_W-1:0]    wrData,
  output logic [ADDR_W-1:0]    physAddr
);
  localparam int IDX_W  = USER_BITS + PAGE_BITS;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int ENT_W  = BASE_BITS + 2;
  localparam int GAP_LO = OFF_BITS + BASE_BITS;
  localparam int GAP_W  = ADDR_W - 2 - GAP_LO;

  logic [ENT_W-1:0]    tbl [DEPTH];
  logic [IDX_W-1:0]    idx;
  logic [ENT_W-1:0]    newEntry;
  logic [ENT_W-1:0]    entryQ;
  logic [OFF_BITS-1:0] offQ;
  logic                showBaseQ;
  logic [GAP_W-1:0]    junkCnt;
  logic [GAP_W-1:0]    junkQ;
  logic                unusedBits;

  assign idx      = {userId, virtAddr[OFF_BITS +: PAGE_BITS]};
  assign newEntry = {wrData[ADDR_W-1], wrData[ADDR_W-2],
                     wrData[OFF_BITS +: BASE_BITS]};
  assign unusedBits = ^{virtAddr[ADDR_W-1:OFF_BITS+PAGE_BITS],
                        wrData[ADDR_W-3:GAP_LO], wrData[OFF_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (strobe.tblWr) tbl[idx] <= newEntry;
  end

  // free-running source for the undefined readback bits
  always_ff @(posedge clk) begin
    if (!rstN) junkCnt <= '0;
    else       junkCnt <= junkCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryQ    <= '0;
      offQ      <= '0;
      showBaseQ <= 1'b0;
      junkQ     <= '0;
    end else if (strobe.lookup) begin
      entryQ    <= tbl[idx];
      offQ      <= virtAddr[OFF_BITS-1:0];
      showBaseQ <= strobe.showBase;
      junkQ     <= junkCnt;
    end
  end

  always_comb begin
    physAddr = {entryQ[ENT_W-1], entryQ[ENT_W-2],
                (showBaseQ ? junkQ : {GAP_W{1'b0}}),
                entryQ[BASE_BITS-1:0],
                (showBaseQ ? {OFF_BITS{1'b0}} : offQ)};
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pt_pkg::*;
#(
  parameter int USER_BITS = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [USER_BITS-1:0] userId,
  input  logic [35:0]          virtAddr,
  input  logic [1:0]           opSel,
  input  logic [35:0]          wrData,
  output logic [35:0]          physAddr
);
  ptStrobe_t strobe;

  pt_ctrl uCtrl (
    .opSel (opSel),
    .strobe(strobe)
  );

  pt_datapath #(
    .USER_BITS(USER_BITS),
    .PAGE_BITS(PAGE_BITS),
    .OFF_BITS (12),
    .BASE_BITS(16),
    .ADDR_W   (36)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .userId  (userId),
    .virtAddr(virtAddr),
    .wrData  (wrData),
    .physAddr(physAddr)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk
  import pt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  opSel,
  input logic [35:0] virtAddr,
  input logic [35:0] physAddr
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> physAddr == 36'd0);  // R7

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_XLATE)
      |-> physAddr[11:0] == $past(virtAddr[11:0]));  // R1

  AST_XLATE_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_XLATE) |-> physAddr[33:28] == 6'd0);  // R2

  AST_READ_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opSel) == OP_READ) |-> physAddr[11:0] == 12'd0);  // R3

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(opSel) == OP_IDLE || $past(opSel) == OP_WRITE))
      |-> $stable(physAddr));  // R6
endmodule

bind page_xlate page_xlate_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .opSel   (opSel),
  .virtAddr(virtAddr),
  .physAddr(physAddr)
);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  userId = '0;
  logic [35:0] virtAddr = '0;
  logic [1:0]  opSel = '0;
  logic [35:0] wrData = '0;
  logic [35:0] physAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  page_xlate u0 (
    .clk(clk), .rstN(rstN), .userId(userId), .virtAddr(virtAddr),
    .opSel(opSel), .wrData(wrData), .physAddr(physAddr)
  );

  localparam logic [35:0] RD_MASK = 36'hC_0FFF_FFFF;
  localparam logic [35:0] ALL     = 36'hF_FFFF_FFFF;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  user;
    logic [35:0] va;
    logic [35:0] wd;
    logic [35:0] expv;
    logic [35:0] mask;   // zero: nothing to compare
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 8'd5,   36'h0_0000_3000, 36'h8_0040_0ABC, 36'h0,           36'h0,   8'd4}, // R4 write
    '{2'd2, 8'd5,   36'h0_0000_3FFF, 36'h0,           36'h8_0040_0000, RD_MASK, 8'd8}, // R8 R3
    '{2'd1, 8'd5,   36'hA_BCD0_3123, 36'h0,           36'h8_0040_0123, ALL,     8'd9}, // R9
    '{2'd3, 8'd6,   36'h0_0000_3555, 36'h7_F123_4FFF, 36'h0,           36'h0,   8'd4}, // R4 ignored bits
    '{2'd1, 8'd5,   36'h0_0000_3000, 36'h0,           36'h8_0040_0000, ALL,     8'd5}, // R5
    '{2'd1, 8'd6,   36'h0_0000_3FFF, 36'h0,           36'h4_0123_4FFF, ALL,     8'd2}, // R2
    '{2'd2, 8'd6,   36'h5_0000_3ABC, 36'h0,           36'h4_0123_4000, RD_MASK, 8'd3}, // R3 R9
    '{2'd3, 8'd5,   36'h0_0000_3000, 36'h0_0FFF_F000, 36'h0,           36'h0,   8'd4},
    '{2'd2, 8'd5,   36'h0_0000_3000, 36'h0,           36'h0_0FFF_F000, RD_MASK, 8'd8}, // R8
    '{2'd1, 8'd6,   36'h0_0000_3001, 36'h0,           36'h4_0123_4001, ALL,     8'd5}, // R5
    '{2'd3, 8'd255, 36'h0_0000_7000, 36'hC_0000_1000, 36'h0,           36'h0,   8'd4},
    '{2'd1, 8'd255, 36'h0_0000_7005, 36'h0,           36'hC_0000_1005, ALL,     8'd1}, // R1
    '{2'd1, 8'd255, 36'h0_0000_7FFF, 36'h0,           36'hC_0000_1FFF, ALL,     8'd1}, // R1
    '{2'd2, 8'd255, 36'h0_0000_7800, 36'h0,           36'hC_0000_1000, RD_MASK, 8'd3}  // R3
  };

  task automatic check(input string req, input logic [35:0] act,
                       input logic [35:0] expv, input logic [35:0] mask);
    checks++;
    if ((act & mask) !== (expv & mask)) begin
      fails++;
      $display("FAIL %s: physAddr actual %h expected %h (mask %h)",
               req, act, expv, mask);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [7:0] u,
                       input logic [35:0] va, input logic [35:0] wd);
    @(negedge clk);
    opSel = op; userId = u; virtAddr = va; wrData = wd;
    @(posedge clk);
    #2;
  endtask

  initial begin
    logic [35:0] held;
    repeat (3) @(posedge clk);
    #2;
    check("R7", physAddr, 36'h0, ALL);  // reset value
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].user, VECS[i].va, VECS[i].wd);
      if (VECS[i].mask != 36'h0)
        check($sformatf("R%0d", VECS[i].req), physAddr, VECS[i].expv, VECS[i].mask);
    end

    // R6: idle keeps the whole output
    held = physAddr;
    apply(2'd0, 8'd9, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF);
    check("R6", physAddr, held, ALL);
    // R6: a table write keeps the whole output
    apply(2'd3, 8'd9, 36'h0_0000_2000, 36'h4_0777_7000);
    check("R6", physAddr, held, ALL);
    // R8: translate right after the write sees it
    apply(2'd1, 8'd9, 36'h0_0000_2ABC, 36'h0);
    check("R8", physAddr, 36'h4_0777_7ABC, ALL);
    // R7: reset mid-run clears the output
    @(negedge clk);
    rstN = 1'b0;
    opSel = 2'd0;
    @(posedge clk);
    #2;
    check("R7", physAddr, 36'h0, ALL);
    @(negedge clk);
    rstN = 1'b1;
    // table contents survive reset; R2 translate after it
    apply(2'd1, 8'd9, 36'h0_0000_2001, 36'h0);
    check("R2", physAddr, 36'h4_0777_7001, ALL);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish");
    end
    #20;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule